// File: doc/BRIEF.md
# Sticky Flash Status Register

This block keeps the 8-bit status byte of a flash memory controller. The program/erase sequencer and the command decoder send it single-cycle event strobes. These strobes report that an operation started or finished, that a program or erase failed, that a suspend was acknowledged, that a resume, sleep or wake was accepted, and that software asked for the status to be cleared. The block turns these strobes into a ready flag, a suspended flag, a sleep flag and two error flags.

The error flags are sticky. Hardware can only set them, so failures from a run of operations add up until software issues a clear. A small state machine tracks the operation state: READY, BUSY, BUSY_SLEEP_PENDING, SUSPENDED and ASLEEP. A sleep request made during an operation is held in BUSY_SLEEP_PENDING and takes effect when the operation finishes. A sleep request made while suspended is dropped.

The byte on `status_o` is frozen while a read access is in progress. The value shown in the cycle where `rd_active` is first sampled high stays on the output until `rd_active` has been sampled low again. Bit map: 7 ready (1 = ready, 0 = busy), 6 erase suspended, 5 erase error, 4 program error, 2 asleep; bits 3, 1 and 0 always read 0.

Transitions, by name:
- READY→BUSY on op_start.
- READY→ASLEEP on sleep_req. op_start wins if both arrive together.
- BUSY→READY on op_done.
- BUSY→SUSPENDED on susp_ack.
- BUSY→BUSY_SLEEP_PENDING on sleep_req.
- In BUSY, op_done takes priority over susp_ack, and susp_ack takes priority over sleep_req.
- BUSY_SLEEP_PENDING→ASLEEP on op_done.
- BUSY_SLEEP_PENDING→SUSPENDED on susp_ack. The pending sleep is discarded.
- SUSPENDED→BUSY on resume.
- ASLEEP→READY on wake.
- Any other strobe is ignored in the state where it arrives.

Top module: `flash_status_reg`

## Requirements
- R1: After reset, status_o reads 80h.
- R2: op_start in READY drives bit 7 to 0 on the next cycle. op_done in BUSY returns bit 7 to 1 and leaves bit 2 at 0.
- R3: susp_ack while busy (and op_done low) sets bits 7 and 6 on the next cycle. resume while suspended clears bit 6 and drives bit 7 to 0 on the next cycle.
- R4: erase_fail sets bit 5 and prog_fail sets bit 4 on the next cycle, in any state.
- R5: Bits 5 and 4 stay set until clr_status, which clears both. A fail strobe in the same cycle as clr_status leaves its bit set. clr_status changes no other bit.
- R6: sleep_req in READY sets bit 2 on the next cycle. wake while asleep clears bit 2. op_start while asleep is ignored.
- R7: sleep_req while busy leaves bit 2 at 0 until op_done. At op_done, bits 7 and 2 become 1 together.
- R8: sleep_req while suspended is ignored. susp_ack while a sleep is pending discards that pending sleep.
- R9: Bits 3, 1 and 0 always read 0.
- R10: Once rd_active has been sampled high, status_o holds the value it showed in that cycle until rd_active has been sampled low.
- R11: op_done, susp_ack or resume outside the states listed in R2/R3, and wake outside ASLEEP, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Program or erase operation started |
| op_done | input | 1 | Running operation finished |
| prog_fail | input | 1 | Program failure event |
| erase_fail | input | 1 | Erase failure event |
| susp_ack | input | 1 | Erase suspend acknowledged |
| resume | input | 1 | Resume command accepted |
| sleep_req | input | 1 | Sleep command accepted |
| wake | input | 1 | Read-array command wakes the device |
| clr_status | input | 1 | Clear-status command |
| rd_active | input | 1 | Status read access in progress |
| status_o | output | 8 | Status byte as seen by the reader |

## Verification
Every strobe is registered once. Its effect on the live status therefore shows on `status_o` one cycle later, provided no read was sampled active at that edge. While `rd_active` is sampled high the output keeps its previous value. The live change appears in the cycle after `rd_active` is first sampled low. The bench drives inputs on the falling edge and compares `status_o` on the next falling edge against a reference model. The model advances exactly one registered step per cycle and uses the same one-cycle freeze register, so every comparison falls in the cycle in which the result is due.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
    localparam int STATUS_W = 8;
    localparam int NUM_ERR  = 2;

    localparam int BIT_READY = 7;
    localparam int BIT_SUSP  = 6;
    localparam int BIT_EERR  = 5;
    localparam int BIT_PERR  = 4;
    localparam int BIT_SLEEP = 2;

    localparam int ERR_IDX_PROG  = 0;
    localparam int ERR_IDX_ERASE = 1;

    typedef enum logic [2:0] {
        ST_READY      = 3'd0,
        ST_BUSY       = 3'd1,
        ST_BUSY_SLPPD = 3'd2,
        ST_SUSPENDED  = 3'd3,
        ST_ASLEEP     = 3'd4
    } op_state_e;
endpackage

// File: rtl/sfsr_seq.sv
module sfsr_seq
    import sfsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_done,
    input  logic susp_ack,
    input  logic resume,
    input  logic sleep_req,
    input  logic wake,
    output logic ready,
    output logic suspended,
    output logic asleep
);
    op_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (op_start)       state_d = ST_BUSY;
                else if (sleep_req) state_d = ST_ASLEEP;
            end
            ST_BUSY: begin
                if (op_done)        state_d = ST_READY;
                else if (susp_ack)  state_d = ST_SUSPENDED;
                else if (sleep_req) state_d = ST_BUSY_SLPPD;
            end
            ST_BUSY_SLPPD: begin
                if (op_done)        state_d = ST_ASLEEP;
                else if (susp_ack)  state_d = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (resume)         state_d = ST_BUSY;
            end
            ST_ASLEEP: begin
                if (wake)           state_d = ST_READY;
            end
            default:                state_d = ST_READY;
        endcase
    end

    always_comb begin
        ready     = 1'b1;
        suspended = 1'b0;
        asleep    = 1'b0;
        unique case (state_q)
            ST_READY:      ;
            ST_BUSY:       ready = 1'b0;
            ST_BUSY_SLPPD: ready = 1'b0;
            ST_SUSPENDED:  suspended = 1'b1;
            ST_ASLEEP:     asleep = 1'b1;
            default:       ;
        endcase
    end
endmodule

// File: rtl/sfsr_errs.sv
module sfsr_errs #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] err_o
);
    for (genvar i = 0; i < N; i++) begin : g_err
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i)    flag_q <= 1'b0;
        end
        assign err_o[i] = flag_q;
    end
endmodule

// File: rtl/sfsr_freeze.sv
module sfsr_freeze #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_active,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] view_o
);
    logic         frozen_q;
    logic [W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen_q <= 1'b0;
            snap_q   <= RST_VAL;
        end else begin
            frozen_q <= rd_active;
            if (!frozen_q) snap_q <= live_i;
        end
    end

    assign view_o = frozen_q ? snap_q : live_i;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import sfsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_start,
    input  logic                op_done,
    input  logic                prog_fail,
    input  logic                erase_fail,
    input  logic                susp_ack,
    input  logic                resume,
    input  logic                sleep_req,
    input  logic                wake,
    input  logic                clr_status,
    input  logic                rd_active,
    output logic [STATUS_W-1:0] status_o
);
    localparam logic [STATUS_W-1:0] RESET_VAL = STATUS_W'(1) << BIT_READY;

    logic                ready, suspended, asleep;
    logic [NUM_ERR-1:0]  err_set, err_q;
    logic [STATUS_W-1:0] live_status;

    sfsr_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_done(op_done),
        .susp_ack(susp_ack), .resume(resume),
        .sleep_req(sleep_req), .wake(wake),
        .ready(ready), .suspended(suspended), .asleep(asleep)
    );

    always_comb begin
        err_set = '0;
        err_set[ERR_IDX_PROG]  = prog_fail;
        err_set[ERR_IDX_ERASE] = erase_fail;
    end

    sfsr_errs #(.N(NUM_ERR)) u_errs (
        .clk(clk), .rst_n(rst_n),
        .set_i(err_set), .clr_i(clr_status),
        .err_o(err_q)
    );

    always_comb begin
        live_status            = '0;
        live_status[BIT_READY] = ready;
        live_status[BIT_SUSP]  = suspended;
        live_status[BIT_EERR]  = err_q[ERR_IDX_ERASE];
        live_status[BIT_PERR]  = err_q[ERR_IDX_PROG];
        live_status[BIT_SLEEP] = asleep;
    end

    sfsr_freeze #(.W(STATUS_W), .RST_VAL(RESET_VAL)) u_frz (
        .clk(clk), .rst_n(rst_n),
        .rd_active(rd_active),
        .live_i(live_status),
        .view_o(status_o)
    );
endmodule

// File: rtl/flash_status_reg_chk.sv
module flash_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic       op_done,
    input logic       erase_fail,
    input logic       susp_ack,
    input logic       resume,
    input logic       sleep_req,
    input logic       wake,
    input logic       clr_status,
    input logic       rd_active,
    input logic [7:0] live,
    input logic [7:0] status_o
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[7] && !live[6] && !live[2] && op_start) |=> !live[7]);

    // R3
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live[7] && susp_ack && !op_done) |=> (live[7] && live[6]));

    // R5
    erase_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[5] && !clr_status) |=> live[5]);

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !erase_fail) |=> !live[5]);

    // R6
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[2] && wake) |=> !live[2]);

    // R8
    no_sleep_in_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[6] && sleep_req && !resume) |=> !live[2]);

    // R10
    read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active)) |=> $stable(status_o));
endmodule

bind flash_status_reg flash_status_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_done(op_done),
    .erase_fail(erase_fail), .susp_ack(susp_ack),
    .resume(resume), .sleep_req(sleep_req), .wake(wake),
    .clr_status(clr_status), .rd_active(rd_active),
    .live(live_status), .status_o(status_o)
);

// File: tb/flash_status_reg_tb.sv
`timescale 1ns/1ps
module flash_status_reg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_done = 0, prog_fail = 0, erase_fail = 0;
    logic susp_ack = 0, resume = 0, sleep_req = 0, wake = 0, clr_status = 0;
    logic rd_active = 0;
    logic [7:0] status_o;

    int n_tests = 0;
    int n_fail  = 0;

    // event vector bit order used by the bench
    localparam int EV_START = 0, EV_DONE = 1, EV_PF = 2, EV_EF = 3, EV_SUSP = 4;
    localparam int EV_RES = 5, EV_SLP = 6, EV_WAKE = 7, EV_CLR = 8;

    // reference model: 0 ready, 1 busy, 2 busy+sleep pending, 3 suspended, 4 asleep
    int         m_st;
    logic       m_e5, m_e4, m_frz;
    logic [7:0] m_snap;

    always #4 clk = ~clk;

    flash_status_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_done(op_done),
        .prog_fail(prog_fail), .erase_fail(erase_fail),
        .susp_ack(susp_ack), .resume(resume),
        .sleep_req(sleep_req), .wake(wake),
        .clr_status(clr_status), .rd_active(rd_active),
        .status_o(status_o)
    );

    function automatic logic [7:0] live_of(int st, logic e5, logic e4);
        logic [7:0] v = '0;
        v[7] = (st != 1) && (st != 2);
        v[6] = (st == 3);
        v[5] = e5;
        v[4] = e4;
        v[2] = (st == 4);
        return v;
    endfunction

    function automatic int next_st(int st, logic [8:0] ev);
        case (st)
            0: return ev[EV_START] ? 1 : (ev[EV_SLP] ? 4 : 0);
            1: return ev[EV_DONE] ? 0 : (ev[EV_SUSP] ? 3 : (ev[EV_SLP] ? 2 : 1));
            2: return ev[EV_DONE] ? 4 : (ev[EV_SUSP] ? 3 : 2);
            3: return ev[EV_RES] ? 1 : 3;
            default: return ev[EV_WAKE] ? 0 : 4;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a, logic [7:0] e);
        logic [7:0] d = a ^ e;
        if (m_frz)          return "R10";
        if (d[3]|d[1]|d[0]) return "R9";
        if (d[5]|d[4])      return "R5";
        if (d[6])           return "R3";
        if (d[2])           return "R6";
        return "R2";
    endfunction

    function automatic logic [7:0] expected();
        return m_frz ? m_snap : live_of(m_st, m_e5, m_e4);
    endfunction

    task automatic check(string tag);
        logic [7:0] e = expected();
        n_tests++;
        if (status_o !== e) begin
            n_fail++;
            $display("FAIL %s: status_o=%02h expected=%02h", (tag == "") ? tag_of(status_o, e) : tag, status_o, e);
        end
    endtask

    // drive at falling edge, let one rising edge pass, check at next falling edge
    task automatic step(logic [8:0] ev, logic rd, string tag);
        logic [7:0] lv;
        op_start = ev[EV_START]; op_done = ev[EV_DONE];
        prog_fail = ev[EV_PF];   erase_fail = ev[EV_EF];
        susp_ack = ev[EV_SUSP];  resume = ev[EV_RES];
        sleep_req = ev[EV_SLP];  wake = ev[EV_WAKE];
        clr_status = ev[EV_CLR]; rd_active = rd;
        lv = live_of(m_st, m_e5, m_e4);
        if (!m_frz) m_snap = lv;
        m_frz = rd;
        m_st  = next_st(m_st, ev);
        m_e5  = ev[EV_EF] | (m_e5 & ~ev[EV_CLR]);
        m_e4  = ev[EV_PF] | (m_e4 & ~ev[EV_CLR]);
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [8:0] E(int b);
        return 9'(1) << b;
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        m_st = 0; m_e5 = 0; m_e4 = 0; m_frz = 0; m_snap = 8'h80;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 start / done
        step(E(EV_START), 0, "R2");
        step(0, 0, "R2");
        step(E(EV_DONE), 0, "R2");
        // R11 stray strobes in READY
        step(E(EV_DONE) | E(EV_SUSP) | E(EV_RES) | E(EV_WAKE), 0, "R11");
        // R3 suspend, R8 sleep ignored while suspended, resume
        step(E(EV_START), 0, "R2");
        step(E(EV_SUSP), 0, "R3");
        step(E(EV_SLP), 0, "R8");
        step(E(EV_DONE), 0, "R11");
        step(E(EV_RES), 0, "R3");
        step(E(EV_DONE), 0, "R2");
        // R7 deferred sleep, R6 op_start ignored while asleep, wake
        step(E(EV_START), 0, "R2");
        step(E(EV_SLP), 0, "R7");
        step(0, 0, "R7");
        step(E(EV_DONE), 0, "R7");
        step(E(EV_START), 0, "R6");
        step(E(EV_WAKE), 0, "R6");
        step(E(EV_SLP), 0, "R6");
        step(E(EV_WAKE), 0, "R6");
        // R8 suspend discards pending sleep
        step(E(EV_START), 0, "R8");
        step(E(EV_SLP), 0, "R8");
        step(E(EV_SUSP), 0, "R8");
        step(E(EV_RES), 0, "R8");
        step(E(EV_DONE), 0, "R8");
        // R4 / R5 sticky errors
        step(E(EV_EF), 0, "R4");
        step(E(EV_PF), 0, "R4");
        step(E(EV_START), 0, "R5");
        step(E(EV_DONE), 0, "R5");
        step(E(EV_CLR), 0, "R5");
        step(E(EV_EF) | E(EV_CLR), 0, "R5");
        step(E(EV_CLR), 0, "R5");
        // R10 read freeze
        step(E(EV_START), 1, "R10");
        step(E(EV_PF), 1, "R10");
        step(E(EV_DONE), 1, "R10");
        step(0, 0, "R10");
        step(E(EV_CLR), 0, "R10");

        // constrained random; R9 reserved bits checked on every step
        for (int i = 0; i < 4000; i++) begin
            logic [8:0] ev = '0;
            for (int b = 0; b < 9; b++) ev[b] = ($urandom_range(0, 99) < 12);
            step(ev, ($urandom_range(0, 99) < 25), "");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule